// File: doc/BRIEF.md
# Fault Snapshot NVM Capture Controller

This controller freezes a small picture of device state when a fault is declared and commits it to two 32-bit rows of non-volatile memory. Two sources can raise a dump request. One is a request bit that software sets and that clears itself once the request is taken. The other is a general-purpose input that is synchronized and edge-detected. On acceptance the controller copies the 8-bit comparator status word and the upper byte of each of the two DAC data words into shadow registers in that same cycle. It then writes only from those copies, so changes at the sources during the slow memory cycle cannot corrupt the record.

The two rows go out on a simple valid/ready write port. The row index and the row word are held steady while the request is waiting. The comparator row is written first and the DAC row second. A busy flag covers the whole dump, and a one-cycle done pulse marks its end. Requests that arrive during a dump are dropped.

Top module: `fault_snap_ctrl`

## Requirements
- R1: A one-cycle pulse on `sw_trig` while idle makes `trig_bit` read 1 after the next clock edge. At the edge after that the dump is accepted: `busy` rises and `trig_bit` returns to 0.
- R2: A low-to-high transition on `gpio_trig` starts a dump. `busy` reads 1 after the third rising clock edge following the change, and not after the second. Holding the input high after the dump starts no second dump.
- R3: The three source bytes are sampled in the acceptance cycle. Changes to `cmp_status`, `dac0_data` or `dac1_data` after acceptance do not alter the row words written.
- R4: The first row written has `nvm_row` = 0, with `cmp_status` in bits 31:24 and zeros in bits 23:0.
- R5: The second row written has `nvm_row` = 1, with `dac1_data[15:8]` in bits 31:24, zeros in bits 23:8 and `dac0_data[15:8]` in bits 7:0.
- R6: Exactly two writes occur per dump, row 0 then row 1. A write completes on a clock edge where `nvm_req` and `nvm_ready` are both 1. While `nvm_req` is 1 and `nvm_ready` is 0, `nvm_req`, `nvm_row` and `nvm_wdata` hold their values.
- R7: `busy` is 1 from acceptance through the edge that completes the row 1 write. `done` is 1 for exactly the one cycle after that edge, and `busy` is 0 in that cycle.
- R8: `sw_trig` pulses and `gpio_trig` edges that arrive while `busy` is 1 are ignored. `trig_bit` stays 0, and no further write occurs after the dump ends.
- R9: While `rst_n` is 0, and after it is released, `busy`, `done`, `nvm_req` and `trig_bit` are 0. An active reset aborts a dump in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_trig | input | 1 | Software write pulse that sets the dump request bit |
| gpio_trig | input | 1 | Asynchronous external dump request, rising edge active |
| cmp_status | input | 8 | Comparator status word |
| dac0_data | input | 16 | DAC channel 0 data word |
| dac1_data | input | 16 | DAC channel 1 data word |
| nvm_ready | input | 1 | Memory port accepts the current write |
| nvm_req | output | 1 | Write request valid |
| nvm_row | output | 1 | Row index of the current write |
| nvm_wdata | output | 32 | Row word of the current write |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle pulse after the last row is written |
| trig_bit | output | 1 | Read-back of the self-clearing request bit |

## Verification
On every cycle the assertions check the following. The write port holds its request, row and word steady while it stalls. The zero fields of both row formats are present. Row 1 follows straight after the row 0 handshake. The done pulse lasts one cycle and comes only after a row 1 handshake. The request bit never reads set during a dump. The bench scenarios alone can show the rest: the data bytes landing in the right fields, values frozen against source changes after acceptance, the exact latency of each trigger path, and that triggers during a dump or a held input never cause an extra write.

// File: rtl/fsnap_pkg.sv
package fsnap_pkg;

    // Sequencer state
    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_state_e;

    // Number of memory rows in one snapshot; the row format is fixed
    localparam int unsigned SNAP_ROWS = 2;

endpackage

// File: rtl/fsnap_trig.sv
module fsnap_trig #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trig_i,
    input  logic gpio_i,
    input  logic busy_i,
    output logic start_o,
    output logic trig_bit_o
);

    // pipe[SYNC_STAGES-1:0] are synchronizer flops, pipe[SYNC_STAGES] keeps the previous level
    typedef struct packed {
        logic [SYNC_STAGES:0] pipe;
        logic                 req_bit;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[SYNC_STAGES-1:0], gpio_i};

        rise    = st_q.pipe[SYNC_STAGES-1] & ~st_q.pipe[SYNC_STAGES];
        start_o = ~busy_i & (st_q.req_bit | rise);

        if (start_o) begin
            st_d.req_bit = 1'b0;
        end else if (sw_trig_i && !busy_i) begin
            st_d.req_bit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_bit_o = st_q.req_bit;

endmodule

// File: rtl/fsnap_pack.sv
module fsnap_pack #(
    parameter int unsigned CMP_W  = 8,
    parameter int unsigned DAC_W  = 16,
    parameter int unsigned ROW_W  = 32,
    parameter int unsigned ROW_IW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [CMP_W-1:0]  cmp_i,
    input  logic [DAC_W-1:0]  dac0_i,
    input  logic [DAC_W-1:0]  dac1_i,
    input  logic [ROW_IW-1:0] row_sel_i,
    output logic [ROW_W-1:0]  row_data_o
);

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic [CMP_W-1:0]  cmp;
        logic [BYTE_W-1:0] dac0_hi;
        logic [BYTE_W-1:0] dac1_hi;
    } shadow_t;

    shadow_t          sh_d, sh_q;
    logic [ROW_W-1:0] row_cmp, row_dac;

    always_comb begin
        sh_d = sh_q;
        if (capture_i) begin
            sh_d.cmp     = cmp_i;
            sh_d.dac0_hi = dac0_i[DAC_W-1 -: BYTE_W];
            sh_d.dac1_hi = dac1_i[DAC_W-1 -: BYTE_W];
        end

        row_cmp                       = '0;
        row_cmp[ROW_W-1 -: CMP_W]     = sh_q.cmp;

        row_dac                       = '0;
        row_dac[ROW_W-1 -: BYTE_W]    = sh_q.dac1_hi;
        row_dac[BYTE_W-1:0]           = sh_q.dac0_hi;

        row_data_o = (row_sel_i == '0) ? row_cmp : row_dac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/fsnap_seq.sv
module fsnap_seq
    import fsnap_pkg::*;
#(
    parameter int unsigned NUM_ROWS = SNAP_ROWS,
    parameter int unsigned ROW_IW   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              nvm_ready_i,
    output logic              nvm_req_o,
    output logic [ROW_IW-1:0] row_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [ROW_IW-1:0] LAST_ROW = ROW_IW'(NUM_ROWS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ROW_IW-1:0] row;
        logic              done;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    sq_d.state = SEQ_WRITE;
                    sq_d.row   = '0;
                end
            end
            SEQ_WRITE: begin
                if (nvm_ready_i) begin
                    if (sq_q.row == LAST_ROW) begin
                        sq_d.state = SEQ_IDLE;
                        sq_d.row   = '0;
                        sq_d.done  = 1'b1;
                    end else begin
                        sq_d.row = sq_q.row + 1'b1;
                    end
                end
            end
            default: sq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{state: SEQ_IDLE, row: '0, done: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign nvm_req_o = (sq_q.state == SEQ_WRITE);
    assign busy_o    = (sq_q.state != SEQ_IDLE);
    assign row_o     = sq_q.row;
    assign done_o    = sq_q.done;

endmodule

// File: rtl/fault_snap_ctrl.sv
module fault_snap_ctrl
    import fsnap_pkg::*;
#(
    parameter int unsigned CMP_W       = 8,
    parameter int unsigned DAC_W       = 16,
    parameter int unsigned ROW_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_trig,
    input  logic             gpio_trig,
    input  logic [CMP_W-1:0] cmp_status,
    input  logic [DAC_W-1:0] dac0_data,
    input  logic [DAC_W-1:0] dac1_data,
    input  logic             nvm_ready,
    output logic             nvm_req,
    output logic             nvm_row,
    output logic [ROW_W-1:0] nvm_wdata,
    output logic             busy,
    output logic             done,
    output logic             trig_bit
);

    localparam int unsigned ROW_IW = 1;

    logic              start;
    logic [ROW_IW-1:0] row_idx;

    fsnap_trig #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_trig_i  (sw_trig),
        .gpio_i     (gpio_trig),
        .busy_i     (busy),
        .start_o    (start),
        .trig_bit_o (trig_bit)
    );

    fsnap_seq #(
        .NUM_ROWS (SNAP_ROWS),
        .ROW_IW   (ROW_IW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .nvm_ready_i (nvm_ready),
        .nvm_req_o   (nvm_req),
        .row_o       (row_idx),
        .busy_o      (busy),
        .done_o      (done)
    );

    fsnap_pack #(
        .CMP_W  (CMP_W),
        .DAC_W  (DAC_W),
        .ROW_W  (ROW_W),
        .ROW_IW (ROW_IW)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (start),
        .cmp_i      (cmp_status),
        .dac0_i     (dac0_data),
        .dac1_i     (dac1_data),
        .row_sel_i  (row_idx),
        .row_data_o (nvm_wdata)
    );

    assign nvm_row = row_idx[0];

endmodule

// File: rtl/fsnap_chk.sv
module fsnap_chk #(
    parameter int unsigned ROW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nvm_ready,
    input logic             nvm_req,
    input logic             nvm_row,
    input logic [ROW_W-1:0] nvm_wdata,
    input logic             busy,
    input logic             done,
    input logic             trig_bit
);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_req && !nvm_ready) |=> (nvm_req && $stable(nvm_row) && $stable(nvm_wdata)));

    p_row_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_req && nvm_ready && !nvm_row) |=> (nvm_req && nvm_row));

    p_row0_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_req && !nvm_row) |-> (nvm_wdata[ROW_W-9:0] == '0));

    p_row1_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_req && nvm_row) |-> (nvm_wdata[ROW_W-9:8] == '0));

    p_req_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_req |-> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(nvm_req && nvm_ready && nvm_row) && !busy));

    p_no_req_bit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !trig_bit);

endmodule

bind fault_snap_ctrl fsnap_chk #(.ROW_W(ROW_W)) u_fsnap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nvm_ready (nvm_ready),
    .nvm_req   (nvm_req),
    .nvm_row   (nvm_row),
    .nvm_wdata (nvm_wdata),
    .busy      (busy),
    .done      (done),
    .trig_bit  (trig_bit)
);

// File: tb/tb_fault_snap_ctrl.sv
module tb_fault_snap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_trig = 1'b0;
    logic        gpio_trig = 1'b0;
    logic [7:0]  cmp_status = '0;
    logic [15:0] dac0_data = '0;
    logic [15:0] dac1_data = '0;
    logic        nvm_ready = 1'b0;
    logic        nvm_req, nvm_row, busy, done, trig_bit;
    logic [31:0] nvm_wdata;

    always #10 clk = ~clk;   // 50 MHz

    fault_snap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .gpio_trig(gpio_trig),
        .cmp_status(cmp_status), .dac0_data(dac0_data), .dac1_data(dac1_data),
        .nvm_ready(nvm_ready), .nvm_req(nvm_req), .nvm_row(nvm_row),
        .nvm_wdata(nvm_wdata), .busy(busy), .done(done), .trig_bit(trig_bit)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory port model: ready after wait_cfg cycles of pending request
    int wait_cfg = 0;
    int wcnt = 0;
    always @(negedge clk) begin
        automatic logic was = nvm_ready;
        if (!nvm_req || was) wcnt = 0; else wcnt++;
        nvm_ready = nvm_req && !was && (wcnt > wait_cfg);
    end

    // Handshake and done recorder
    int          ncap = 0;
    int          done_cnt = 0;
    logic        cap_row [4];
    logic [31:0] cap_dat [4];
    always @(posedge clk) begin
        if (rst_n && nvm_req && nvm_ready) begin
            if (ncap < 4) begin
                cap_row[ncap] = nvm_row;
                cap_dat[ncap] = nvm_wdata;
            end
            ncap++;
        end
        if (rst_n && done) done_cnt++;
    end

    typedef struct packed {
        logic [7:0]  cmp;
        logic [15:0] d0;
        logic [15:0] d1;
        logic        use_gpio;
        logic [3:0]  wt;
        logic [31:0] row0;
        logic [31:0] row1;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 16'h1234, 16'hABCD, 1'b0, 4'd0, 32'hA500_0000, 32'hAB00_0012},
        '{8'h3C, 16'hFF00, 16'h0080, 1'b1, 4'd3, 32'h3C00_0000, 32'h0000_00FF},
        '{8'h00, 16'h80FF, 16'h7F01, 1'b0, 4'd1, 32'h0000_0000, 32'h7F00_0080},
        '{8'hFF, 16'h00FF, 16'hFFFF, 1'b1, 4'd0, 32'hFF00_0000, 32'hFF00_0000}
    };

    task automatic wait_done();
        for (int i = 0; i < 200 && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic sw_pulse();
        @(negedge clk) sw_trig = 1'b1;
        @(negedge clk) sw_trig = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !nvm_req && !trig_bit, "R9", "outputs in reset",
            {28'd0, busy, done, nvm_req, trig_bit}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !nvm_req && !trig_bit, "R9", "outputs after release",
            {28'd0, busy, done, nvm_req, trig_bit}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            wait_cfg   = int'(VECS[v].wt);
            cmp_status = VECS[v].cmp;
            dac0_data  = VECS[v].d0;
            dac1_data  = VECS[v].d1;
            ncap       = 0;
            done_cnt   = 0;
            if (VECS[v].use_gpio) begin
                @(negedge clk) gpio_trig = 1'b1;
                @(negedge clk);
                @(negedge clk);
                chk(!busy, "R2", "busy two edges after gpio rise", {31'd0, busy}, 32'd0);
                @(negedge clk);
                chk(busy, "R2", "busy three edges after gpio rise", {31'd0, busy}, 32'd1);
            end else begin
                sw_pulse();
                chk(trig_bit && !busy, "R1", "request bit set, not yet busy",
                    {30'd0, trig_bit, busy}, 32'd2);
                @(negedge clk);
                chk(busy && !trig_bit, "R1", "accepted and bit cleared",
                    {30'd0, trig_bit, busy}, 32'd1);
            end
            // R3: scramble sources after acceptance
            cmp_status = ~VECS[v].cmp;
            dac0_data  = ~VECS[v].d0;
            dac1_data  = ~VECS[v].d1;
            wait_done();
            @(negedge clk);
            @(negedge clk);
            chk(ncap == 2, "R6", "write count", 32'(ncap), 32'd2);
            chk(cap_row[0] == 1'b0 && cap_row[1] == 1'b1, "R6", "row order",
                {30'd0, cap_row[0], cap_row[1]}, 32'd1);
            chk(cap_dat[0] == VECS[v].row0, "R4", "row 0 word", cap_dat[0], VECS[v].row0);
            chk(cap_dat[1] == VECS[v].row1, "R5", "row 1 word (R3 frozen)", cap_dat[1], VECS[v].row1);
            chk(done_cnt == 1, "R7", "done pulse count", 32'(done_cnt), 32'd1);
            chk(!busy, "R7", "busy after done", {31'd0, busy}, 32'd0);
            if (VECS[v].use_gpio) begin
                repeat (8) @(negedge clk);
                chk(!busy && ncap == 2, "R2", "held gpio level no restart",
                    32'(ncap), 32'd2);
                gpio_trig = 1'b0;
                repeat (4) @(negedge clk);
            end
        end

        // R8: triggers during a dump are ignored
        wait_cfg   = 6;
        ncap       = 0;
        done_cnt   = 0;
        cmp_status = 8'h5A;
        dac0_data  = 16'hC300;
        dac1_data  = 16'h1100;
        sw_pulse();
        @(negedge clk);
        chk(busy, "R8", "dump started", {31'd0, busy}, 32'd1);
        sw_pulse();
        chk(!trig_bit, "R8", "request bit stays clear while busy", {31'd0, trig_bit}, 32'd0);
        gpio_trig = 1'b1;
        repeat (2) @(negedge clk);
        gpio_trig = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk(ncap == 2 && !busy, "R8", "no extra dump after busy triggers", 32'(ncap), 32'd2);
        chk(cap_dat[1] == 32'h1100_00C3, "R5", "row 1 word directed", cap_dat[1], 32'h1100_00C3);
        chk(!trig_bit, "R8", "request bit clear at end", {31'd0, trig_bit}, 32'd0);

        // R9: reset aborts a dump in progress
        wait_cfg = 10;
        sw_pulse();
        @(negedge clk);
        chk(busy, "R9", "dump running before reset", {31'd0, busy}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !nvm_req && !done, "R9", "reset aborts dump",
            {29'd0, busy, nvm_req, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !trig_bit, "R9", "idle after abort", {30'd0, busy, trig_bit}, 32'd0);

        finish_run();
    end

endmodule